// File: doc/BRIEF.md
# InfoFrame Packet Assembler with Checksum

The block turns a set of parallel field inputs into the body of one of two auxiliary video packets: a video-format InfoFrame (AVI) or an audio InfoFrame. A one-cycle `start` pulse captures every field input together with the kind selector. The block then adds up the header and the payload one byte per clock to form the checksum byte, and sends the body as little-endian data words over a valid/ready stream. `out_last` marks the final word.

The fixed three-byte header of the packet in flight (type, version, length) sits on a side port for the downstream data-island formatter. That formatter, together with error-correction coding and blanking-period scheduling, sits outside this block. Each packet body starts with its checksum byte. The checksum is chosen so that the header bytes plus every body byte add to zero modulo 256.

The word width is a parameter and must be a multiple of eight bits. Body bytes that fall beyond the packet's length inside the final word are sent as zero.

Top module: `ifr_pkt_asm`

## Requirements
- R1: `out_hdr` carries the header of the packet in flight, with type in bits [7:0], version in [15:8] and length in [23:16]. `kind_sel`=0 selects AVI (type 0x82, version 0x02, length 13). `kind_sel`=1 selects audio (type 0x84, version 0x01, length 10).
- R2: Body byte 0 equals 0x100 minus the modulo-256 sum of the three header bytes and payload bytes 1..length, reduced to 8 bits. Header plus body therefore sums to 0 modulo 256.
- R3: AVI payload bytes 1 to 3 are packed as follows.
  - Byte 1: colour format in [6:5] (0 RGB, 1 YCbCr 4:2:2, 2 YCbCr 4:4:4), active-format-present in bit 4, bar-valid in [3:2], scan in [1:0].
  - Byte 2: colorimetry in [7:6], picture aspect in [5:4], active-format aspect in [3:0].
  - Byte 3: IT-content flag in bit 7, extended colorimetry in [6:4], quantization range in [3:2], non-uniform scaling in [1:0].
- R4: AVI byte 4 holds the 7-bit video code in [6:0] and byte 5 holds the 4-bit pixel repetition in [3:0]. The bar values follow as 16-bit little-endian pairs, low byte first: top in bytes 6-7, bottom in 8-9, left in 10-11, right in 12-13.
- R5: Audio payload bytes are packed as follows, and bytes 6 to 10 are zero.
  - Byte 1: coding type in [7:4], channel count minus one in [2:0].
  - Byte 2: sample frequency in [4:2], sample size in [1:0].
  - Byte 3: format byte.
  - Byte 4: channel allocation.
  - Byte 5: downmix-inhibit in bit 7, level shift in [6:3].
- R6: Body bytes are packed WORD_W/8 per word, with the lowest-index byte in bits [7:0]. Pad bytes after the last body byte are zero. With WORD_W=32, an AVI packet takes 4 words and an audio packet takes 3. `out_last` is high exactly on the final word.
- R7: `out_valid` first rises `length` clock edges after the edge that captured `start`: 13 for AVI, 10 for audio. `busy` is high from the capture edge until the final word is accepted.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R9: Field inputs and `kind_sel` are sampled only on the accepted `start`. Later changes do not alter the packet in flight.
- R10: A `start` pulse while `busy` is high is ignored.
- R11: After reset, `out_valid`, `out_last` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture fields and begin a packet (ignored while busy) |
| kind_sel | input | 1 | 0 = AVI packet, 1 = audio packet |
| avi_scan | input | 2 | Scan information |
| avi_bar_vld | input | 2 | Bar data valid flags |
| avi_afd_present | input | 1 | Active format information present |
| avi_color | input | 2 | Colour format |
| avi_afar | input | 4 | Active format aspect ratio |
| avi_pic_aspect | input | 2 | Picture aspect ratio |
| avi_colorimetry | input | 2 | Colorimetry |
| avi_nups | input | 2 | Non-uniform picture scaling |
| avi_quant | input | 2 | Quantization range |
| avi_ext_col | input | 3 | Extended colorimetry |
| avi_itc | input | 1 | IT content flag |
| avi_vic | input | 7 | Video format code |
| avi_pixrep | input | 4 | Pixel repetition |
| avi_bar_top | input | 16 | Top bar line |
| avi_bar_bot | input | 16 | Bottom bar line |
| avi_bar_left | input | 16 | Left bar pixel |
| avi_bar_right | input | 16 | Right bar pixel |
| aud_chan_m1 | input | 3 | Channel count minus one |
| aud_coding | input | 4 | Coding type |
| aud_ssize | input | 2 | Sample size |
| aud_sfreq | input | 3 | Sample frequency |
| aud_fmt | input | 8 | Format byte |
| aud_alloc | input | 8 | Channel allocation |
| aud_lshift | input | 4 | Level shift value |
| aud_dm_inh | input | 1 | Downmix inhibit |
| out_valid | output | 1 | Word available |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | WORD_W | Body word, lowest byte index in [7:0] |
| out_last | output | 1 | Final word of the packet |
| out_hdr | output | 24 | Header of the packet in flight |
| busy | output | 1 | A packet is being summed or sent |

## Verification
The bench builds the block with the default WORD_W=32. This width leaves two zero pad bytes in the last AVI word and one in the last audio word, so partial final words are exercised for both kinds. The bench runs hand-computed vectors for each byte layout. It also runs randomised packets of both kinds with an irregular `out_ready` pattern, fields changed every cycle during flight, and `start` pulses while busy. A behavioural model checks valid, busy, last, header and data on every cycle.

// File: rtl/ifr_pkg.sv
package ifr_pkg;

   typedef enum logic {
      KIND_AVI = 1'b0,
      KIND_AUD = 1'b1
   } ifr_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SUM  = 2'd1,
      ST_EMIT = 2'd2
   } ifr_state_e;

   localparam logic [7:0] AVI_TYPE = 8'h82;
   localparam logic [7:0] AVI_VER  = 8'h02;
   localparam logic [7:0] AVI_LEN  = 8'd13;
   localparam logic [7:0] AUD_TYPE = 8'h84;
   localparam logic [7:0] AUD_VER  = 8'h01;
   localparam logic [7:0] AUD_LEN  = 8'd10;

   localparam int MAX_LEN    = (AVI_LEN > AUD_LEN) ? int'(AVI_LEN) : int'(AUD_LEN);
   localparam int BODY_BYTES = MAX_LEN + 1;
   localparam int IDX_W      = $clog2(BODY_BYTES);

   typedef logic [BODY_BYTES-1:0][7:0] body_t;

   typedef struct packed {
      logic [1:0]  scan;
      logic [1:0]  bar_vld;
      logic        afd_present;
      logic [1:0]  color;
      logic [3:0]  afar;
      logic [1:0]  pic_aspect;
      logic [1:0]  colorimetry;
      logic [1:0]  nups;
      logic [1:0]  quant;
      logic [2:0]  ext_col;
      logic        itc;
      logic [6:0]  vic;
      logic [3:0]  pixrep;
      logic [15:0] bar_top;
      logic [15:0] bar_bot;
      logic [15:0] bar_left;
      logic [15:0] bar_right;
   } avi_fields_t;

   typedef struct packed {
      logic [2:0] chan_m1;
      logic [3:0] coding;
      logic [1:0] ssize;
      logic [2:0] sfreq;
      logic [7:0] fmt;
      logic [7:0] alloc;
      logic [3:0] lshift;
      logic       dm_inh;
   } aud_fields_t;

   function automatic logic [23:0] hdr_of(ifr_kind_e k);
      return (k == KIND_AVI) ? {AVI_LEN, AVI_VER, AVI_TYPE}
                             : {AUD_LEN, AUD_VER, AUD_TYPE};
   endfunction

   function automatic logic [7:0] hdr_sum(ifr_kind_e k);
      logic [23:0] h;
      h = hdr_of(k);
      return h[7:0] + h[15:8] + h[23:16];
   endfunction

endpackage

// File: rtl/ifr_field_pack.sv
module ifr_field_pack
   import ifr_pkg::*;
(
   input  ifr_kind_e   kind,
   input  avi_fields_t avi,
   input  aud_fields_t aud,
   output body_t       body
);

   localparam int NBARS = 4;

   body_t              avi_b;
   body_t              aud_b;
   logic [NBARS-1:0][15:0] bars;

   assign bars[0] = avi.bar_top;
   assign bars[1] = avi.bar_bot;
   assign bars[2] = avi.bar_left;
   assign bars[3] = avi.bar_right;

   // bar pairs: low byte first, starting at body byte 6
   localparam int BAR_BASE = 6;

   always_comb begin
      avi_b    = '0;
      avi_b[1] = {1'b0, avi.color, avi.afd_present, avi.bar_vld, avi.scan};
      avi_b[2] = {avi.colorimetry, avi.pic_aspect, avi.afar};
      avi_b[3] = {avi.itc, avi.ext_col, avi.quant, avi.nups};
      avi_b[4] = {1'b0, avi.vic};
      avi_b[5] = {4'b0, avi.pixrep};
      for (int i = 0; i < NBARS; i++) begin
         avi_b[BAR_BASE + 2*i]     = bars[i][7:0];
         avi_b[BAR_BASE + 2*i + 1] = bars[i][15:8];
      end
   end

   always_comb begin
      aud_b    = '0;
      aud_b[1] = {aud.coding, 1'b0, aud.chan_m1};
      aud_b[2] = {3'b0, aud.sfreq, aud.ssize};
      aud_b[3] = aud.fmt;
      aud_b[4] = aud.alloc;
      aud_b[5] = {aud.dm_inh, aud.lshift, 3'b0};
   end

   assign body = (kind == KIND_AVI) ? avi_b : aud_b;

endmodule

// File: rtl/ifr_csum_ctl.sv
module ifr_csum_ctl
   import ifr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  ifr_kind_e kind_in,
   input  body_t     body_in,
   input  logic      tx_done,
   output logic      emit_act,
   output logic      busy,
   output ifr_kind_e kind_q,
   output body_t     body_out
);

   localparam logic [IDX_W-1:0] AVI_END = IDX_W'(AVI_LEN);
   localparam logic [IDX_W-1:0] AUD_END = IDX_W'(AUD_LEN);

   ifr_state_e       state_q;
   body_t            frame_q;
   logic [IDX_W-1:0] idx_q;
   logic [7:0]       sum_q;
   logic [IDX_W-1:0] end_idx;

   assign end_idx = (kind_q == KIND_AVI) ? AVI_END : AUD_END;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         frame_q <= '0;
         idx_q   <= '0;
         sum_q   <= '0;
         kind_q  <= KIND_AVI;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  frame_q <= body_in;
                  kind_q  <= kind_in;
                  sum_q   <= hdr_sum(kind_in);
                  idx_q   <= IDX_W'(1);
                  state_q <= ST_SUM;
               end
            end
            ST_SUM: begin
               sum_q <= sum_q + frame_q[idx_q];
               idx_q <= idx_q + IDX_W'(1);
               if (idx_q == end_idx) state_q <= ST_EMIT;
            end
            ST_EMIT: begin
               if (tx_done) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      body_out    = frame_q;
      body_out[0] = 8'h00 - sum_q;
   end

   assign emit_act = (state_q == ST_EMIT);
   assign busy     = (state_q != ST_IDLE);

endmodule

// File: rtl/ifr_word_tx.sv
module ifr_word_tx
   import ifr_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  ifr_kind_e         kind,
   input  body_t             body,
   input  logic              ready,
   output logic              valid,
   output logic [WORD_W-1:0] data,
   output logic              last,
   output logic              done
);

   localparam int WB        = WORD_W / 8;
   localparam int NWORD_MAX = (BODY_BYTES + WB - 1) / WB;
   localparam int PAD_BYTES = NWORD_MAX * WB;
   localparam int WIDX_W    = (NWORD_MAX > 1) ? $clog2(NWORD_MAX) : 1;
   localparam int AVI_NW    = (int'(AVI_LEN) + 1 + WB - 1) / WB;
   localparam int AUD_NW    = (int'(AUD_LEN) + 1 + WB - 1) / WB;
   localparam logic [WIDX_W-1:0] AVI_LAST_W = WIDX_W'(AVI_NW - 1);
   localparam logic [WIDX_W-1:0] AUD_LAST_W = WIDX_W'(AUD_NW - 1);

   logic [PAD_BYTES-1:0][7:0]        padded;
   logic [NWORD_MAX-1:0][WORD_W-1:0] words;
   logic [WIDX_W-1:0]                widx_q;
   logic [WIDX_W-1:0]                last_w;

   for (genvar b = 0; b < PAD_BYTES; b++) begin : g_pad
      if (b < BODY_BYTES) begin : g_body
         assign padded[b] = body[b];
      end else begin : g_zero
         assign padded[b] = 8'h00;
      end
   end

   for (genvar w = 0; w < NWORD_MAX; w++) begin : g_word
      assign words[w] = padded[w*WB +: WB];
   end

   assign last_w = (kind == KIND_AVI) ? AVI_LAST_W : AUD_LAST_W;

   always_ff @(posedge clk) begin
      if (!rst_n || !active) begin
         widx_q <= '0;
      end else if (ready) begin
         widx_q <= (widx_q == last_w) ? '0 : widx_q + WIDX_W'(1);
      end
   end

   assign valid = active;
   assign data  = words[widx_q];
   assign last  = active && (widx_q == last_w);
   assign done  = last && ready;

endmodule

// File: rtl/ifr_pkt_asm.sv
module ifr_pkt_asm
   import ifr_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              kind_sel,
   input  logic [1:0]        avi_scan,
   input  logic [1:0]        avi_bar_vld,
   input  logic              avi_afd_present,
   input  logic [1:0]        avi_color,
   input  logic [3:0]        avi_afar,
   input  logic [1:0]        avi_pic_aspect,
   input  logic [1:0]        avi_colorimetry,
   input  logic [1:0]        avi_nups,
   input  logic [1:0]        avi_quant,
   input  logic [2:0]        avi_ext_col,
   input  logic              avi_itc,
   input  logic [6:0]        avi_vic,
   input  logic [3:0]        avi_pixrep,
   input  logic [15:0]       avi_bar_top,
   input  logic [15:0]       avi_bar_bot,
   input  logic [15:0]       avi_bar_left,
   input  logic [15:0]       avi_bar_right,
   input  logic [2:0]        aud_chan_m1,
   input  logic [3:0]        aud_coding,
   input  logic [1:0]        aud_ssize,
   input  logic [2:0]        aud_sfreq,
   input  logic [7:0]        aud_fmt,
   input  logic [7:0]        aud_alloc,
   input  logic [3:0]        aud_lshift,
   input  logic              aud_dm_inh,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_data,
   output logic              out_last,
   output logic [23:0]       out_hdr,
   output logic              busy
);

   if ((WORD_W % 8) != 0 || WORD_W < 8 || WORD_W > 128) begin : g_bad_width
      $error("ifr_pkt_asm: WORD_W must be a multiple of 8 in 8..128");
   end

   avi_fields_t avi_f;
   aud_fields_t aud_f;
   body_t       body_new;
   body_t       body_cs;
   ifr_kind_e   kind_q;
   logic        emit_act;
   logic        tx_done;

   assign avi_f.scan        = avi_scan;
   assign avi_f.bar_vld     = avi_bar_vld;
   assign avi_f.afd_present = avi_afd_present;
   assign avi_f.color       = avi_color;
   assign avi_f.afar        = avi_afar;
   assign avi_f.pic_aspect  = avi_pic_aspect;
   assign avi_f.colorimetry = avi_colorimetry;
   assign avi_f.nups        = avi_nups;
   assign avi_f.quant       = avi_quant;
   assign avi_f.ext_col     = avi_ext_col;
   assign avi_f.itc         = avi_itc;
   assign avi_f.vic         = avi_vic;
   assign avi_f.pixrep      = avi_pixrep;
   assign avi_f.bar_top     = avi_bar_top;
   assign avi_f.bar_bot     = avi_bar_bot;
   assign avi_f.bar_left    = avi_bar_left;
   assign avi_f.bar_right   = avi_bar_right;

   assign aud_f.chan_m1 = aud_chan_m1;
   assign aud_f.coding  = aud_coding;
   assign aud_f.ssize   = aud_ssize;
   assign aud_f.sfreq   = aud_sfreq;
   assign aud_f.fmt     = aud_fmt;
   assign aud_f.alloc   = aud_alloc;
   assign aud_f.lshift  = aud_lshift;
   assign aud_f.dm_inh  = aud_dm_inh;

   ifr_field_pack u_pack (
      .kind (ifr_kind_e'(kind_sel)),
      .avi  (avi_f),
      .aud  (aud_f),
      .body (body_new)
   );

   ifr_csum_ctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .kind_in  (ifr_kind_e'(kind_sel)),
      .body_in  (body_new),
      .tx_done  (tx_done),
      .emit_act (emit_act),
      .busy     (busy),
      .kind_q   (kind_q),
      .body_out (body_cs)
   );

   ifr_word_tx #(.WORD_W(WORD_W)) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .active(emit_act),
      .kind  (kind_q),
      .body  (body_cs),
      .ready (out_ready),
      .valid (out_valid),
      .data  (out_data),
      .last  (out_last),
      .done  (tx_done)
   );

   assign out_hdr = hdr_of(kind_q);

endmodule

// File: rtl/ifr_pkt_asm_chk.sv
module ifr_pkt_asm_chk
   import ifr_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              out_valid,
   input logic              out_ready,
   input logic              out_last,
   input logic [WORD_W-1:0] out_data,
   input logic [23:0]       out_hdr
);

   localparam int WB = WORD_W / 8;

   logic [7:0] acc_q;
   logic       mid_q;
   logic [7:0] word_sum;
   logic [7:0] base_sum;
   logic [7:0] run_sum;

   always_comb begin
      word_sum = '0;
      for (int i = 0; i < WB; i++) word_sum = word_sum + out_data[i*8 +: 8];
   end

   assign base_sum = mid_q ? acc_q : (out_hdr[7:0] + out_hdr[15:8] + out_hdr[23:16]);
   assign run_sum  = base_sum + word_sum;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         mid_q <= 1'b0;
      end else if (out_valid && out_ready) begin
         mid_q <= !out_last;
         acc_q <= run_sum;
      end
   end

   // R2
   csum_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |-> (run_sum == 8'h00));

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

   // R6
   last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

   // R6
   end_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> !out_valid);

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !out_valid);

   // R10
   hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(out_hdr));

   // R1
   hdr_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_hdr == 24'h0D0282 || out_hdr == 24'h0A0184));

endmodule

bind ifr_pkt_asm ifr_pkt_asm_chk #(.WORD_W(WORD_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_last  (out_last),
   .out_data  (out_data),
   .out_hdr   (out_hdr)
);

// File: tb/ifr_pkt_asm_tb.sv
module ifr_pkt_asm_tb;

   localparam int WORD_W = 32;
   localparam int WB     = WORD_W / 8;

   logic clk = 1'b0;
   logic rst_n, start, kind_sel, out_ready;
   logic [1:0] avi_scan, avi_bar_vld, avi_color, avi_pic_aspect, avi_colorimetry, avi_nups, avi_quant;
   logic avi_afd_present, avi_itc, aud_dm_inh;
   logic [3:0] avi_afar, avi_pixrep, aud_coding, aud_lshift;
   logic [2:0] avi_ext_col, aud_chan_m1, aud_sfreq;
   logic [6:0] avi_vic;
   logic [15:0] avi_bar_top, avi_bar_bot, avi_bar_left, avi_bar_right;
   logic [1:0] aud_ssize;
   logic [7:0] aud_fmt, aud_alloc;
   logic out_valid, out_last, busy;
   logic [WORD_W-1:0] out_data;
   logic [23:0] out_hdr;

   always #10 clk = ~clk;

   ifr_pkt_asm #(.WORD_W(WORD_W)) u_dut (.*);

   int n_chk = 0;
   int n_fail = 0;
   bit done_flag = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   int m_phase = 0;
   int m_cnt = 0;
   logic [WORD_W-1:0] m_q[$];
   logic [23:0] m_hdr = 24'h0;
   logic [WORD_W-1:0] got[$];

   function automatic void fill_q(bit k);
      logic [7:0] b [0:63];
      logic [WORD_W-1:0] w;
      int len, nw, s;
      for (int i = 0; i < 64; i++) b[i] = 8'h00;
      if (!k) begin
         len = 13; m_hdr = 24'h0D0282;
         b[1] = 8'(avi_color) << 5 | 8'(avi_afd_present) << 4 | 8'(avi_bar_vld) << 2 | 8'(avi_scan);
         b[2] = 8'(avi_colorimetry) << 6 | 8'(avi_pic_aspect) << 4 | 8'(avi_afar);
         b[3] = 8'(avi_itc) << 7 | 8'(avi_ext_col) << 4 | 8'(avi_quant) << 2 | 8'(avi_nups);
         b[4] = 8'(avi_vic);
         b[5] = 8'(avi_pixrep);
         b[6] = avi_bar_top[7:0];   b[7]  = avi_bar_top[15:8];
         b[8] = avi_bar_bot[7:0];   b[9]  = avi_bar_bot[15:8];
         b[10] = avi_bar_left[7:0]; b[11] = avi_bar_left[15:8];
         b[12] = avi_bar_right[7:0]; b[13] = avi_bar_right[15:8];
      end else begin
         len = 10; m_hdr = 24'h0A0184;
         b[1] = 8'(aud_coding) << 4 | 8'(aud_chan_m1);
         b[2] = 8'(aud_sfreq) << 2 | 8'(aud_ssize);
         b[3] = aud_fmt;
         b[4] = aud_alloc;
         b[5] = 8'(aud_dm_inh) << 7 | 8'(aud_lshift) << 3;
      end
      s = int'(m_hdr[7:0]) + int'(m_hdr[15:8]) + int'(m_hdr[23:16]);
      for (int i = 1; i <= len; i++) s += int'(b[i]);
      b[0] = 8'((256 - (s % 256)) % 256);
      nw = (len + 1 + WB - 1) / WB;
      for (int j = 0; j < nw; j++) begin
         w = '0;
         for (int i = 0; i < WB; i++) w[i*8 +: 8] = b[j*WB + i];
         m_q.push_back(w);
      end
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0;
         m_q.delete();
      end else begin
         case (m_phase)
            0: if (start) begin
                  fill_q(kind_sel);
                  m_cnt = kind_sel ? 10 : 13;
                  m_phase = 1;
               end
            1: begin
                  m_cnt--;
                  if (m_cnt == 0) m_phase = 2;
               end
            default: if (out_ready) begin
                  void'(m_q.pop_front());
                  if (m_q.size() == 0) m_phase = 0;
               end
         endcase
      end
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         // R11 reset state
         chk(out_valid === 1'b0 && out_last === 1'b0 && busy === 1'b0, "R11 reset",
             {61'b0, out_valid, out_last, busy}, 64'h0);
      end else if (!done_flag) begin
         chk(out_valid === (m_phase == 2), "R7 valid timing", 64'(out_valid), 64'(m_phase == 2));
         chk(busy === (m_phase != 0), "R7 R10 busy", 64'(busy), 64'(m_phase != 0));
         if (m_phase == 2) begin
            chk(out_data === m_q[0], "R3 R4 R5 R6 R8 R9 data", 64'(out_data), 64'(m_q[0]));
            chk(out_last === (m_q.size() == 1), "R6 last", 64'(out_last), 64'(m_q.size() == 1));
            chk(out_hdr === m_hdr, "R1 header", 64'(out_hdr), 64'(m_hdr));
         end
         if (out_valid && out_ready) got.push_back(out_data);
      end
   end

   task automatic zero_fields();
      {avi_scan, avi_bar_vld, avi_afd_present, avi_color, avi_afar, avi_pic_aspect} = '0;
      {avi_colorimetry, avi_nups, avi_quant, avi_ext_col, avi_itc, avi_vic, avi_pixrep} = '0;
      {avi_bar_top, avi_bar_bot, avi_bar_left, avi_bar_right} = '0;
      {aud_chan_m1, aud_coding, aud_ssize, aud_sfreq, aud_fmt, aud_alloc, aud_lshift, aud_dm_inh} = '0;
   endtask

   task automatic rand_fields();
      {avi_scan, avi_bar_vld, avi_afd_present, avi_color, avi_afar, avi_pic_aspect} = 13'($urandom);
      {avi_colorimetry, avi_nups, avi_quant, avi_ext_col, avi_itc, avi_vic, avi_pixrep} = 23'($urandom);
      {avi_bar_top, avi_bar_bot} = $urandom;
      {avi_bar_left, avi_bar_right} = $urandom;
      {aud_chan_m1, aud_coding, aud_ssize, aud_sfreq, aud_fmt, aud_alloc, aud_lshift, aud_dm_inh} = 33'({$urandom, $urandom});
   endtask

   // mode 0: ready always; mode 1: irregular ready, field churn (R9), start while busy (R10)
   task automatic send(input bit k, input int mode);
      int cyc;
      got.delete();
      @(posedge clk); #2;
      start = 1'b1; kind_sel = k; out_ready = 1'b1;
      @(posedge clk); #2;
      start = 1'b0;
      cyc = 0;
      while (m_phase != 0) begin
         if (mode == 1) begin
            out_ready = ($urandom % 3) != 0;
            rand_fields();
            kind_sel = 1'($urandom);
            start = (m_phase == 1) && (m_cnt > 2) && (($urandom % 2) == 0);
         end
         @(posedge clk); #2;
         start = 1'b0;
         cyc++;
      end
      out_ready = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      rst_n = 1'b0; start = 1'b0; kind_sel = 1'b0; out_ready = 1'b1;
      zero_fields();
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // AVI with all-zero fields: checksum 0x100-0x91 = 0x6F
      send(1'b0, 0);
      chk(got.size() == 4, "R6 AVI word count", 64'(got.size()), 64'd4);
      chk(got[0] === 32'h0000006F, "R2 AVI zero checksum", 64'(got[0]), 64'h6F);

      // audio, two channels: byte1=0x01, checksum 0x70
      aud_chan_m1 = 3'd1;
      send(1'b1, 0);
      chk(got.size() == 3, "R6 audio word count", 64'(got.size()), 64'd3);
      chk(got[0] === 32'h00000170, "R2 R5 audio checksum", 64'(got[0]), 64'h170);

      // AVI top bar 0x1234
      zero_fields();
      avi_bar_top = 16'h1234;
      send(1'b0, 0);
      chk(got[0] === 32'h00000029, "R4 bar checksum", 64'(got[0]), 64'h29);
      chk(got[1] === 32'h12340000, "R4 top bar bytes", 64'(got[1]), 64'h12340000);

      // AVI bytes 1-3
      zero_fields();
      avi_scan = 2'd1; avi_bar_vld = 2'd2; avi_afd_present = 1'b1; avi_color = 2'd2;
      avi_afar = 4'd8; avi_pic_aspect = 2'd2; avi_colorimetry = 2'd1;
      avi_nups = 2'd3; avi_quant = 2'd1; avi_ext_col = 3'd5; avi_itc = 1'b1;
      send(1'b0, 0);
      chk(got[0] === 32'hD76859D7, "R3 AVI bytes 0-3", 64'(got[0]), 64'hD76859D7);

      // audio bytes 1-5
      zero_fields();
      aud_chan_m1 = 3'd7; aud_coding = 4'd1; aud_ssize = 2'd3; aud_sfreq = 3'd5;
      aud_fmt = 8'hAB; aud_alloc = 8'h13; aud_lshift = 4'hF; aud_dm_inh = 1'b1;
      send(1'b1, 0);
      chk(got[0] === 32'hAB17178D, "R5 audio bytes 0-3", 64'(got[0]), 64'hAB17178D);
      chk(got[1] === 32'h0000F813, "R5 audio bytes 4-7", 64'(got[1]), 64'h0000F813);
      chk(got[2] === 32'h00000000, "R5 audio zero tail", 64'(got[2]), 64'h0);

      // randomised packets with stalls, churn and busy starts
      for (int n = 0; n < 40; n++) begin
         bit k;
         k = 1'($urandom);
         rand_fields();
         send(k, 1);
         chk(got.size() == (k ? 3 : 4), "R6 R10 words per packet", 64'(got.size()), k ? 64'd3 : 64'd4);
      end

      repeat (3) @(posedge clk);
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         done_flag = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule